// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the purely combinational execute stage for a processor's sixteen data-processing operations. It takes the first register operand, the already-shifted second operand with the shifter's carry-out, a set-flags bit, the destination register index, the opcode and the current four condition flags. From these it produces the result word and a register write-enable. It also produces the next flag value and a flag write-enable, and a request to restore the status register from its saved copy.

There are three operation classes. Logical operations and moves take carry from the shifter and keep overflow. Additions take carry from bit 31 and compute signed overflow. Subtractions report carry as "no borrow" and compute signed overflow. The four test/compare operations never write a register and always update the flags. A flag-setting write to the program-counter index does not update the flags. Instead it raises the restore request for the surrounding mode logic, which holds the saved status copy.

Top module: `dp_alu`

## Requirements
- R1: Opcode encoding is AND=0, EOR=1, SUB=2, RSB=3, ADD=4, ADC=5, SBC=6, RSC=7, TST=8, TEQ=9, CMP=10, CMN=11, ORR=12, MOV=13, BIC=14, MVN=15. The arithmetic results are as follows: SUB/CMP give rn−op2, RSB gives op2−rn, ADD/CMN give rn+op2, ADC gives rn+op2+C, SBC gives rn−op2−NOT C and RSC gives op2−rn−NOT C, all modulo 2^32.
- R2: The logical results are as follows: AND/TST give rn&op2, EOR/TEQ give rn^op2, ORR gives rn|op2, MOV gives op2, BIC gives rn&~op2 and MVN gives ~op2.
- R3: Opcodes 8 to 11 hold the register write-enable low and drive the flag write-enable high whatever the set-flags bit and destination index are.
- R4: Flags are packed as nzcv[3]=N, [2]=Z, [1]=C, [0]=V. When flags are written, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R5: For AND, EOR, TST, TEQ, ORR, MOV, BIC and MVN, a flag write sets C to the shifter carry-out and passes V through from the input.
- R6: For ADD, ADC and CMN, C is the carry out of bit 31. V is 1 when both addends have the same sign and the result sign differs from that sign.
- R7: For SUB, RSB, SBC, RSC and CMP, C is 1 exactly when no borrow occurs. V is 1 when the operand signs differ and the result sign differs from the minuend's sign.
- R8: A writing opcode with the set-flags bit high and destination index 15 raises the restore request. The flag write-enable then stays low and the flag output equals the input. The restore request is low in every other case.
- R9: A writing opcode with the set-flags bit low gives a low flag write-enable, and the flag output equals the flag input.
- R10: Every opcode outside 8 to 11 drives the register write-enable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 4 | Operation select (encoding in R1) |
| rn_i | input | 32 | First register operand |
| op2_i | input | 32 | Shifted second operand |
| shc_i | input | 1 | Shifter carry-out |
| set_flags_i | input | 1 | Set-flags bit of the instruction |
| rd_idx_i | input | 4 | Destination register index |
| nzcv_i | input | 4 | Current flags N,Z,C,V (bits 3..0) |
| result_o | output | 32 | Operation result |
| reg_we_o | output | 1 | Destination register write-enable |
| nzcv_o | output | 4 | Next flags N,Z,C,V |
| flag_we_o | output | 1 | Flag write-enable |
| restore_req_o | output | 1 | Request to restore status from the saved copy |

## Verification
Two functions can coincide on the same input vector: a flag-setting write to index 15 and a flag update. The same holds for a compare with destination 15, where a forced flag update meets a destination index that would request a restore. The sweep drives every opcode with set-flags high and low and the destination at 3 and 15. It expects exactly one of restore request or flag write when a writing opcode sets flags toward 15, and a flag write with no restore for the compare opcodes. Corner operands are 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF, with each carry and overflow input value. They push the carry, borrow and overflow rules onto their boundaries, and a 64-bit reference model judges every output.

// File: rtl/dp_alu_pkg.sv
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_LOGIC = 2'd0,
    CLS_ADD   = 2'd1,
    CLS_SUB   = 2'd2
  } op_class_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic op_class_e op_class(alu_op_e op);
    case (op)
      OP_ADD, OP_ADC, OP_CMN:                 return CLS_ADD;
      OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return CLS_SUB;
      default:                                return CLS_LOGIC;
    endcase
  endfunction

  function automatic logic op_is_test(alu_op_e op);
    return (op == OP_TST) || (op == OP_TEQ) || (op == OP_CMP) || (op == OP_CMN);
  endfunction

endpackage

// File: rtl/dp_logic_unit.sv
module dp_logic_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR, OP_TEQ: res = a ^ b;
      OP_ORR:         res = a | b;
      OP_MOV:         res = b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/dp_arith_unit.sv
module dp_arith_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] rn,
  input  logic [WIDTH-1:0] op2,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  // Full add of x + y + cin, returned with the carry in the top bit.
  function automatic logic [WIDTH:0] add_carry(logic [WIDTH-1:0] x,
                                               logic [WIDTH-1:0] y,
                                               logic             cin);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
  endfunction

  logic             swap_ops;
  logic             invert_y;
  logic             add_cin;
  logic [WIDTH-1:0] x_opnd;
  logic [WIDTH-1:0] y_opnd;
  logic [WIDTH:0]   sum;

  always_comb begin
    swap_ops = (op == OP_RSB) || (op == OP_RSC);
    invert_y = (op_class(op) == CLS_SUB);
    case (op)
      OP_ADC, OP_SBC, OP_RSC: add_cin = c_in;
      OP_SUB, OP_RSB, OP_CMP: add_cin = 1'b1;
      default:                add_cin = 1'b0;
    endcase
    x_opnd = swap_ops ? op2 : rn;
    y_opnd = swap_ops ? rn  : op2;
    if (invert_y) y_opnd = ~y_opnd;
    sum   = add_carry(x_opnd, y_opnd, add_cin);
    res   = sum[MSB:0];
    carry = sum[WIDTH];
    ovf   = (x_opnd[MSB] == y_opnd[MSB]) && (sum[MSB] != x_opnd[MSB]);
  end

  always_comb begin
    if (op_class(op) == CLS_ADD && ovf)
      AST_ADD_OVF_SIGNS: assert (rn[MSB] == op2[MSB] && res[MSB] != rn[MSB]); // R6
    if ((op == OP_SUB || op == OP_CMP) && rn == op2)
      AST_EQUAL_SUB_NO_BORROW: assert (carry && res == '0); // R7
  end

endmodule

// File: rtl/dp_flag_unit.sv
module dp_flag_unit
  import dp_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  op_class_e        cls,
  input  logic [WIDTH-1:0] res,
  input  logic             arith_c,
  input  logic             arith_v,
  input  logic             shc,
  input  logic [3:0]       nzcv_in,
  output logic [3:0]       nzcv_new
);

  always_comb begin
    nzcv_new[FLAG_N] = res[WIDTH-1];
    nzcv_new[FLAG_Z] = (res == '0);
    if (cls == CLS_LOGIC) begin
      nzcv_new[FLAG_C] = shc;
      nzcv_new[FLAG_V] = nzcv_in[FLAG_V];
    end else begin
      nzcv_new[FLAG_C] = arith_c;
      nzcv_new[FLAG_V] = arith_v;
    end
  end

  always_comb begin
    if (cls == CLS_LOGIC)
      AST_LOGIC_KEEPS_V: assert (nzcv_new[FLAG_V] == nzcv_in[FLAG_V] && nzcv_new[FLAG_C] == shc); // R5
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int RIDX_W  = 4,
  parameter int PC_IDX  = 15
) (
  input  logic [3:0]        opcode_i,
  input  logic [WIDTH-1:0]  rn_i,
  input  logic [WIDTH-1:0]  op2_i,
  input  logic              shc_i,
  input  logic              set_flags_i,
  input  logic [RIDX_W-1:0] rd_idx_i,
  input  logic [3:0]        nzcv_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              reg_we_o,
  output logic [3:0]        nzcv_o,
  output logic              flag_we_o,
  output logic              restore_req_o
);

  localparam logic [RIDX_W-1:0] PC_SEL = RIDX_W'(PC_IDX);

  alu_op_e          op;
  op_class_e        cls;
  logic             is_test;
  logic [WIDTH-1:0] logic_res;
  logic [WIDTH-1:0] arith_res;
  logic             arith_c;
  logic             arith_v;
  logic [3:0]       nzcv_calc;
  logic             writes_rd;
  logic             to_pc;

  assign op      = alu_op_e'(opcode_i);
  assign cls     = op_class(op);
  assign is_test = op_is_test(op);

  dp_logic_unit #(.WIDTH(WIDTH)) u_logic (
    .op  (op),
    .a   (rn_i),
    .b   (op2_i),
    .res (logic_res)
  );

  dp_arith_unit #(.WIDTH(WIDTH)) u_arith (
    .op    (op),
    .rn    (rn_i),
    .op2   (op2_i),
    .c_in  (nzcv_i[FLAG_C]),
    .res   (arith_res),
    .carry (arith_c),
    .ovf   (arith_v)
  );

  always_comb result_o = (cls == CLS_LOGIC) ? logic_res : arith_res;

  dp_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .cls      (cls),
    .res      (result_o),
    .arith_c  (arith_c),
    .arith_v  (arith_v),
    .shc      (shc_i),
    .nzcv_in  (nzcv_i),
    .nzcv_new (nzcv_calc)
  );

  always_comb begin
    writes_rd     = !is_test;
    to_pc         = (rd_idx_i == PC_SEL);
    reg_we_o      = writes_rd;
    restore_req_o = writes_rd && set_flags_i && to_pc;
    flag_we_o     = is_test || (set_flags_i && !restore_req_o);
    nzcv_o        = flag_we_o ? nzcv_calc : nzcv_i;
  end

  always_comb begin
    AST_RESTORE_EXCLUSIVE: assert (!(restore_req_o && flag_we_o)); // R8
    if (!flag_we_o)
      AST_HOLD_FLAGS: assert (nzcv_o == nzcv_i); // R9
    if (opcode_i[3:2] == 2'b10)
      AST_TEST_NO_WRITE: assert (!reg_we_o && flag_we_o && !restore_req_o); // R3
    if (flag_we_o)
      AST_ZERO_FLAG: assert (nzcv_o[FLAG_Z] == (result_o == '0)); // R4
  end

endmodule

// File: tb/tb_dp_alu.sv
`timescale 1ns/1ps
module tb_dp_alu;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0]  opcode_i;
  logic [31:0] rn_i, op2_i;
  logic        shc_i, set_flags_i;
  logic [3:0]  rd_idx_i, nzcv_i;
  logic [31:0] result_o;
  logic        reg_we_o, flag_we_o, restore_req_o;
  logic [3:0]  nzcv_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dp_alu dut (
    .opcode_i(opcode_i), .rn_i(rn_i), .op2_i(op2_i), .shc_i(shc_i),
    .set_flags_i(set_flags_i), .rd_idx_i(rd_idx_i), .nzcv_i(nzcv_i),
    .result_o(result_o), .reg_we_o(reg_we_o), .nzcv_o(nzcv_o),
    .flag_we_o(flag_we_o), .restore_req_o(restore_req_o)
  );

  // Reference model with 64-bit integer arithmetic.
  task automatic ref_model(input logic [3:0] opc, input logic [31:0] a, input logic [31:0] b,
                           input logic sc, input logic s, input logic [3:0] rd, input logic [3:0] f,
                           output logic [31:0] r, output logic we, output logic [3:0] fo,
                           output logic fwe, output logic rst, output int cls);
    longint unsigned ua, ub, full, m, sub, bi;
    longint sa, sb, sres;
    logic c, v;
    ua = {32'd0, a}; ub = {32'd0, b};
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = 1'b0; v = 1'b0; r = '0; cls = 0;
    case (opc)
      4'd4, 4'd5, 4'd11: begin
        cls  = 1;
        bi   = (opc == 4'd5) ? longint'(f[1]) : 0;
        full = ua + ub + bi;
        r    = full[31:0];
        c    = full[32];
        sres = sa + sb + longint'(bi);
        v    = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
      end
      4'd2, 4'd3, 4'd6, 4'd7, 4'd10: begin
        cls = 2;
        bi  = (opc == 4'd6 || opc == 4'd7) ? longint'(!f[1]) : 0;
        if (opc == 4'd3 || opc == 4'd7) begin
          m = ub; sub = ua; sres = sb - sa - longint'(bi);
        end else begin
          m = ua; sub = ub; sres = sa - sb - longint'(bi);
        end
        full = m - sub - bi;
        r    = full[31:0];
        c    = (m >= sub + bi);
        v    = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
      end
      4'd0, 4'd8: r = a & b;
      4'd1, 4'd9: r = a ^ b;
      4'd12:      r = a | b;
      4'd13:      r = b;
      4'd14:      r = a & ~b;
      default:    r = ~b;
    endcase
    we  = !(opc >= 4'd8 && opc <= 4'd11);
    rst = we && s && (rd == 4'd15);
    fwe = !we || (s && !rst);
    if (cls == 0) begin c = sc; v = f[0]; end
    fo = fwe ? {r[31], (r == 32'd0), c, v} : f;
  endtask

  task automatic apply(input logic [3:0] opc, input logic [31:0] a, input logic [31:0] b,
                       input logic sc, input logic s, input logic [3:0] rd, input logic [3:0] f);
    logic [31:0] er; logic ewe, efwe, erst; logic [3:0] ef; int cls;
    @(negedge clk);
    opcode_i = opc; rn_i = a; op2_i = b; shc_i = sc; set_flags_i = s; rd_idx_i = rd; nzcv_i = f;
    ref_model(opc, a, b, sc, s, rd, f, er, ewe, ef, efwe, erst, cls);
    @(posedge clk); #1;
    checks++;
    if (result_o !== er) begin
      fails++;
      $display("FAIL %s op=%0d result act=%h exp=%h", (cls == 0) ? "R2" : "R1", opc, result_o, er);
    end else if (reg_we_o !== ewe) begin
      fails++;
      $display("FAIL %s op=%0d reg_we act=%b exp=%b", ewe ? "R10" : "R3", opc, reg_we_o, ewe);
    end else if (restore_req_o !== erst) begin
      fails++;
      $display("FAIL R8 op=%0d restore act=%b exp=%b", opc, restore_req_o, erst);
    end else if (flag_we_o !== efwe) begin
      fails++;
      $display("FAIL %s op=%0d flag_we act=%b exp=%b", !ewe ? "R3" : (erst ? "R8" : "R9"),
               opc, flag_we_o, efwe);
    end else if (nzcv_o !== ef) begin
      fails++;
      if (!efwe)
        $display("FAIL R9 op=%0d nzcv act=%b exp=%b", opc, nzcv_o, ef);
      else if (nzcv_o[3:2] !== ef[3:2])
        $display("FAIL R4 op=%0d nzcv act=%b exp=%b", opc, nzcv_o, ef);
      else
        $display("FAIL %s op=%0d nzcv act=%b exp=%b",
                 (cls == 0) ? "R5" : ((cls == 1) ? "R6" : "R7"), opc, nzcv_o, ef);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [5];
    corner[0] = 32'h0; corner[1] = 32'h1; corner[2] = 32'h7FFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'hFFFF_FFFF;
    opcode_i = '0; rn_i = '0; op2_i = '0; shc_i = 0; set_flags_i = 0; rd_idx_i = '0; nzcv_i = '0;
    repeat (2) @(posedge clk);
    // Idle state: AND of zeros, no flag write (R9), register write (R10).
    apply(4'd0, 32'd0, 32'd0, 1'b0, 1'b0, 4'd0, 4'b0101);
    // Corner sweep over every opcode: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10.
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          for (int k = 0; k < 32; k++)
            apply(4'(op), corner[i], corner[j], k[0], k[1], k[2] ? 4'd15 : 4'd3,
                  {k[4], 1'b0, k[3], ~k[4]});
    // Random operands, all opcodes, all flag inputs.
    for (int n = 0; n < 4000; n++)
      apply(4'($urandom), $urandom, $urandom, 1'($urandom), 1'($urandom),
            4'($urandom), 4'($urandom));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule